// File: doc/BRIEF.md
# Segmented Scan Register with Recirculating Hold

The block is the scan path of a protected test scheme. A register of scan flip-flops is cut into NSEG equal segments. All segments listen to one serial input, and every segment shifts on every clock while test mode is active.

A per-segment enable chooses what enters a segment's head cell. When the enable is high, the head cell takes the shared serial input. When it is low, the head cell takes the segment's own tail, so the segment rotates without losing anything. After one slot of SEGLEN cycles, a rotating segment is back in its original alignment.

An external controller drives the enables, one segment per slot. Each segment's tail goes out to that controller's output selector. When test mode is low for a cycle, every cell captures its functional input.

If the number of real flip-flops NFF is not a multiple of NSEG, dummy cells are appended so that all segments have the same length.

Top module: `scan_seg_array`

## Requirements
- R1: Segment length SEGLEN is NFF/NSEG rounded up. Dummy cells numbering NSEG-(NFF mod NSEG) are added when NFF mod NSEG is nonzero, and none are added otherwise. Dummy cells occupy the highest chain indices and capture 0.
- R2: Segment s holds `chain_q[s*SEGLEN +: SEGLEN]`. Its head cell is index s*SEGLEN, and its tail cell is index s*SEGLEN+SEGLEN-1, which drives `seg_tail[s]`.
- R3: With `test_mode`=1 and `seg_en[s]`=1, the head of segment s takes `scan_in` at the clock edge.
- R4: With `test_mode`=1 and `seg_en[s]`=0, the head of segment s takes that segment's own tail bit from before the edge.
- R5: With `test_mode`=1, every non-head cell takes the value of the cell below it in the same segment, whatever the enables.
- R6: A segment held disabled for SEGLEN consecutive shift cycles ends with exactly the contents it had before them.
- R7: With `test_mode`=0, every real cell i takes `func_d[i]` in a single edge.
- R8: An active-low `rst_n` asynchronously clears every cell to 0.
- R9: Suppose one-hot enables select segments one slot of SEGLEN cycles each, in any order, while pattern bits p[0..] are shifted in. After NSEG*SEGLEN cycles, cell j of the segment loaded in slot k holds p[k*SEGLEN+SEGLEN-1-j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| test_mode | input | 1 | 1 = shift, 0 = functional capture |
| scan_in | input | 1 | Shared serial input for all segments |
| seg_en | input | NSEG | Per-segment load enable |
| func_d | input | NFF | Functional data inputs of the real cells |
| seg_tail | output | NSEG | Tail bit of each segment |
| chain_q | output | NSEG*SEGLEN | Contents of all cells, dummies included |

## Verification
A wrong head-mux choice shows on the segment's own cells one edge later. It also reaches that segment's tail SEGLEN-1 edges after that. Per-cycle comparison of every cell catches it within one clock.

A broken rotation is invisible at the tail until the slot ends. The slot-end restoration check and the full-load pattern check expose it after SEGLEN cycles. A capture or padding error appears on the very next edge after `test_mode` falls.

// File: rtl/scan_seg_array.sv
module scan_seg_array #(
  parameter int NSEG = 4,
  parameter int NFF  = 10
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    test_mode,
  input  logic                                    scan_in,
  input  logic [NSEG-1:0]                         seg_en,
  input  logic [NFF-1:0]                          func_d,
  output logic [NSEG-1:0]                         seg_tail,
  output logic [NSEG*((NFF+NSEG-1)/NSEG)-1:0]     chain_q
);
  localparam int PAD    = (NFF % NSEG == 0) ? 0 : NSEG - (NFF % NSEG);
  localparam int TOTAL  = NFF + PAD;
  localparam int SEGLEN = TOTAL / NSEG;

  logic [TOTAL-1:0] q, nxt, cap_val;

  assign cap_val = TOTAL'(func_d);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int BASE = s * SEGLEN;
    localparam int TAIL = BASE + SEGLEN - 1;

    assign nxt[BASE] = test_mode ? (seg_en[s] ? scan_in : q[TAIL]) : cap_val[BASE];
    assign seg_tail[s] = q[TAIL];

    for (genvar j = 1; j < SEGLEN; j++) begin : g_cell
      assign nxt[BASE+j] = test_mode ? q[BASE+j-1] : cap_val[BASE+j];

      assert_body_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> chain_q[BASE+j] == $past(chain_q[BASE+j-1]));
    end

    assert_head_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && seg_en[s]) |=> chain_q[BASE] == $past(scan_in));

    assert_head_recirc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !seg_en[s]) |=> chain_q[BASE] == $past(seg_tail[s]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign chain_q = q;

  for (genvar i = 0; i < NFF; i++) begin : g_capchk
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |=> chain_q[i] == $past(func_d[i]));
  end

  for (genvar d = NFF; d < TOTAL; d++) begin : g_dummy
    assert_dummy_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |=> chain_q[d] == 1'b0);
  end
endmodule

// File: tb/tb_scan_seg_array.sv
module tb_scan_seg_array;
  localparam int CLK_P  = 10;
  localparam int NSEG   = 4;
  localparam int NFF    = 10;
  localparam int SEGLEN = (NFF + NSEG - 1) / NSEG;
  localparam int TOTAL  = NSEG * SEGLEN;

  logic clk = 0, rst_n = 1, test_mode = 1, scan_in = 0;
  logic [NSEG-1:0] seg_en = '0;
  logic [NFF-1:0]  func_d = '0;
  logic [NSEG-1:0] seg_tail;
  logic [TOTAL-1:0] chain_q;

  scan_seg_array #(.NSEG(NSEG), .NFF(NFF)) dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_in(scan_in),
    .seg_en(seg_en), .func_d(func_d), .seg_tail(seg_tail), .chain_q(chain_q));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  logic sq [NSEG][$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NSEG; s++) begin
      sq[s].delete();
      for (int j = 0; j < SEGLEN; j++) sq[s].push_back(1'b0);
    end
  endtask

  task automatic compare_all(input bit tm, input logic [NSEG-1:0] en);
    for (int s = 0; s < NSEG; s++) begin
      string hreq;
      hreq = !tm ? "R7" : (en[s] ? "R3" : "R4");
      chk(chain_q[s*SEGLEN] === sq[s][0], hreq, chain_q[s*SEGLEN], sq[s][0]);
      for (int j = 1; j < SEGLEN; j++)
        chk(chain_q[s*SEGLEN+j] === sq[s][j], tm ? "R5" : "R7", chain_q[s*SEGLEN+j], sq[s][j]);
      chk(seg_tail[s] === sq[s][SEGLEN-1], "R2", seg_tail[s], sq[s][SEGLEN-1]);
    end
  endtask

  task automatic step(input bit tm, input bit si, input logic [NSEG-1:0] en, input logic [NFF-1:0] fd);
    test_mode = tm; scan_in = si; seg_en = en; func_d = fd;
    @(posedge clk);
    for (int s = 0; s < NSEG; s++) begin
      if (tm) begin
        logic b;
        b = en[s] ? si : sq[s][SEGLEN-1];
        sq[s].push_front(b);
        void'(sq[s].pop_back());
      end else begin
        for (int j = 0; j < SEGLEN; j++) begin
          int idx;
          idx = s*SEGLEN + j;
          sq[s][j] = (idx < NFF) ? fd[idx] : 1'b0;
        end
      end
    end
    @(negedge clk);
    compare_all(tm, en);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(chain_q === '0, "R8", chain_q, 0);
    @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int ord_a [NSEG] = '{2, 0, 3, 1};
    int ord_b [NSEG] = '{1, 3, 0, 2};
    logic [TOTAL-1:0] pat;
    logic [TOTAL-1:0] snap;
    logic [TOTAL-1:0] exp_full;

    #2 rst_n = 0;
    #1;
    chk(chain_q === '0, "R8", chain_q, 0);
    @(negedge clk);
    rst_n = 1;
    model_clear();

    chk(SEGLEN == 3 && TOTAL - NFF == NSEG - (NFF % NSEG), "R1", TOTAL - NFF, NSEG - (NFF % NSEG));

    step(0, 0, '0, 10'h2B6);
    chk(chain_q[TOTAL-1:NFF] === '0, "R1", chain_q[TOTAL-1:NFF], 0);
    step(0, 0, '0, 10'h3FF);
    chk(chain_q[TOTAL-1:NFF] === '0, "R1", chain_q[TOTAL-1:NFF], 0);

    pat = 12'hA5C;
    for (int k = 0; k < NSEG; k++) begin
      snap = chain_q;
      for (int c = 0; c < SEGLEN; c++)
        step(1, pat[k*SEGLEN + c], NSEG'(1) << ord_a[k], '0);
      for (int s = 0; s < NSEG; s++)
        if (s != ord_a[k])
          chk(chain_q[s*SEGLEN +: SEGLEN] === snap[s*SEGLEN +: SEGLEN], "R6",
              chain_q[s*SEGLEN +: SEGLEN], snap[s*SEGLEN +: SEGLEN]);
    end
    exp_full = '0;
    for (int k = 0; k < NSEG; k++)
      for (int j = 0; j < SEGLEN; j++)
        exp_full[ord_a[k]*SEGLEN + j] = pat[k*SEGLEN + SEGLEN-1-j];
    chk(chain_q === exp_full, "R9", chain_q, exp_full);

    step(0, 0, '0, 10'h1C9);
    for (int k = 0; k < NSEG; k++)
      for (int c = 0; c < SEGLEN; c++)
        step(1, c[0], NSEG'(1) << ord_b[k], '0);

    for (int c = 0; c < 5; c++) step(1, c[1], '1, '0);
    for (int c = 0; c < 5; c++) step(1, 1'b1, '0, '0);
    for (int c = 0; c < 4; c++) step(1, ~c[0], 4'b0101, '0);

    do_reset();
    compare_all(1, '0);
    step(1, 1, 4'b1000, '0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule